// File: doc/BRIEF.md
# Prescaled Tick Counter with Compare Flags

This block is a counter for slow, long-interval timekeeping. A 10-bit prescaler divides the oscillator clock by a selectable power of two and produces a one-cycle count tick. The counter advances on that tick, and only while the block is enabled. It reports wrap-around and compare matches through sticky flags. Surrounding logic clears each flag with a one-cycle strobe.

The counter runs in one of two layouts. In the wide layout it is a free-running 32-bit counter with one 32-bit compare value. An optional clear-on-match turns that compare value into a period. In the split layout only the low 16 bits count. They wrap at a programmable 16-bit period and are checked against two independent 16-bit compare values. A load port lets surrounding logic preset the count at any time. This is how long intervals are set up and tested without waiting for them to elapse.

Top module: `pscnt_top`

## Requirements
- R1: After reset, `count` is zero and all three flags are low.
- R2: With select code k in 0..10, the counter advances once every 2^k enabled clock cycles. The first advance comes on the 2^k-th rising clock edge at which `en` is high. Codes 11 to 15 behave as code 10.
- R3: While `en` is low the count holds and the prescaler returns to zero. After `en` rises again, the first advance takes a full 2^k enabled cycles.
- R4: In the wide layout (`mode` = 0), a tick at count 0xFFFFFFFF moves the count to 0x00000000 and sets `ovf_flag` at the same clock edge.
- R5: In the wide layout, `cmp0_flag` is set at the tick that moves the count away from a value equal to `cmp0_val`. It therefore rises one tick after the count first shows the match.
- R6: In the wide layout with `clr_on_match` high, a tick at a count equal to `cmp0_val` loads zero instead of incrementing. It sets `ovf_flag` and `cmp0_flag` at the same edge, so the count repeats with period `cmp0_val`+1.
- R7: In the split layout (`mode` = 1), `count[31:16]` reads zero. A tick at a low half equal to `per_val`, or at 0xFFFF, moves the count to zero and sets `ovf_flag`. Any other tick adds one, so the period is `per_val`+1.
- R8: In the split layout, `cmp0_flag` is set by a tick at a low half equal to `cmp0_val[15:0]`, and `cmp1_flag` by a tick at a low half equal to `cmp1_val`. The upper half of `cmp0_val` is ignored, and so is `clr_on_match`. `cmp1_flag` is never set in the wide layout.
- R9: A high `cnt_load` replaces the count at the next clock edge, whether or not the block is enabled. In the split layout only `cnt_load_val[15:0]` is taken. A tick in the same cycle is discarded and sets no flag.
- R10: Flags are sticky until their clear strobe (`ovf_clr`, `cmp0_clr`, `cmp1_clr`) is high at a clock edge. A set and a clear of the same flag at one edge leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable; low holds count and restarts the prescaler |
| mode | input | 1 | 0 = wide 32-bit layout, 1 = split 16-bit layout |
| psc_sel | input | 4 | Prescaler code k, divide by 2^k (k clamped to 10) |
| clr_on_match | input | 1 | Wide layout: compare match restarts the count from zero |
| cnt_load | input | 1 | Load strobe for the count |
| cnt_load_val | input | 32 | Value written by the load strobe |
| per_val | input | 16 | Split layout period (top count) |
| cmp0_val | input | 32 | Compare value 0 (low 16 bits in split layout) |
| cmp1_val | input | 16 | Compare value 1 (split layout only) |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| cmp0_clr | input | 1 | Clear strobe for compare flag 0 |
| cmp1_clr | input | 1 | Clear strobe for compare flag 1 |
| count | output | 32 | Current count |
| ovf_flag | output | 1 | Sticky overflow / wrap flag |
| cmp0_flag | output | 1 | Sticky compare 0 flag |
| cmp1_flag | output | 1 | Sticky compare 1 flag |

## Verification
The hardest case to reach is a wrap of the full 32-bit count that falls on the same edge as an overflow clear strobe. Counting up to it would take billions of ticks. The stimulus uses the load port to preset the count a few values below all-ones with the prescaler at code 0, so that every enabled cycle is a tick. The clear strobe can then be placed on the exact wrap edge. The prescaler periods are measured by counting cycles from the rise of `en` to each change of the count, for every select code including the clamped ones. Period, compare and clear-on-match behaviour are swept over small values and compared tick by tick against an arithmetic model.

// File: rtl/pscnt_pkg.sv
package pscnt_pkg;
   typedef enum logic {
      MODE_WIDE  = 1'b0,
      MODE_SPLIT = 1'b1
   } cnt_mode_e;

   localparam int FLAG_OVF  = 0;
   localparam int FLAG_CMP0 = 1;
   localparam int FLAG_CMP1 = 2;
   localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/pscnt_prescaler.sv
module pscnt_prescaler #(
   parameter int PSC_W = 10,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam logic [SEL_W-1:0] MAX_CODE = SEL_W'(PSC_W);

   if (PSC_W < 1 || (2 ** SEL_W) <= PSC_W) begin : g_bad_cfg
      $error("pscnt_prescaler: select width cannot encode every divide code");
   end

   logic [PSC_W-1:0] psc_q;
   logic [PSC_W-1:0] mask;
   logic [SEL_W-1:0] code_c;

   // codes above the prescaler width saturate at the widest divide
   assign code_c = (sel > MAX_CODE) ? MAX_CODE : sel;

   // low code_c bits of the mask are ones
   for (genvar i = 0; i < PSC_W; i++) begin : g_mask
      assign mask[i] = (code_c > SEL_W'(i));
   end

   assign tick = en && ((psc_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   psc_q <= '0;
      else if (!en) psc_q <= '0;
      else          psc_q <= psc_q + 1'b1;
   end

   // R3: a fresh enable always starts from a cleared prescaler
   assert_psc_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> (psc_q == '0));
   // R2: no tick is produced while disabled
   assert_no_idle_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !tick);
endmodule

// File: rtl/pscnt_core.sv
module pscnt_core
   import pscnt_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              mode,
   input  logic              clr_on_match,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_val,
   input  logic [HALF_W-1:0] per,
   input  logic [CNT_W-1:0]  cmp0,
   input  logic [HALF_W-1:0] cmp1,
   output logic [CNT_W-1:0]  count,
   output logic              set_ovf,
   output logic              set_cmp0,
   output logic              set_cmp1
);
   localparam int               UP_W      = CNT_W - HALF_W;
   localparam logic [CNT_W-1:0] ALL_ONES  = {CNT_W{1'b1}};
   localparam logic [HALF_W-1:0] HALF_ONES = {HALF_W{1'b1}};

   if (HALF_W < 1 || HALF_W >= CNT_W) begin : g_bad_cfg
      $error("pscnt_core: split width must be below the full width");
   end

   cnt_mode_e         mode_e;
   logic              is_split;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [HALF_W-1:0] lo;
   logic              hit_w0, hit_s0, hit_s1;

   assign mode_e   = cnt_mode_e'(mode);
   assign is_split = (mode_e == MODE_SPLIT);
   assign lo       = cnt_q[HALF_W-1:0];
   assign hit_w0   = (cnt_q == cmp0);
   assign hit_s0   = (lo == cmp0[HALF_W-1:0]);
   assign hit_s1   = (lo == cmp1);

   always_comb begin
      cnt_d    = cnt_q;
      set_ovf  = 1'b0;
      set_cmp0 = 1'b0;
      set_cmp1 = 1'b0;
      if (load) begin
         cnt_d = is_split ? {{UP_W{1'b0}}, load_val[HALF_W-1:0]} : load_val;
      end else if (tick) begin
         if (!is_split) begin
            set_cmp0 = hit_w0;
            if ((clr_on_match && hit_w0) || (cnt_q == ALL_ONES)) begin
               cnt_d   = '0;
               set_ovf = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end else begin
            set_cmp0 = hit_s0;
            set_cmp1 = hit_s1;
            if ((lo == per) || (lo == HALF_ONES)) begin
               cnt_d   = '0;
               set_ovf = 1'b1;
            end else begin
               cnt_d = {{UP_W{1'b0}}, lo + 1'b1};
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count = is_split ? {{UP_W{1'b0}}, lo} : cnt_q;

   // R2: the count only moves on a tick or a load
   assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt_q));
   // R9: a wide-layout load lands on the next edge
   assert_load_wide_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !is_split) |=> (cnt_q == $past(load_val)));
   // R9: a load suppresses every flag event
   assert_load_no_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !(set_ovf || set_cmp0 || set_cmp1));
endmodule

// File: rtl/pscnt_flags.sv
module pscnt_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   if (N < 1) begin : g_bad_cfg
      $error("pscnt_flags: at least one flag required");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flags[i] <= 1'b0;
         else if (set[i]) flags[i] <= 1'b1;
         else if (clr[i]) flags[i] <= 1'b0;
      end

      // R10: a set event beats a clear in the same cycle
      assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags[i]);
      // R10: a flag stays up until cleared
      assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !clr[i]) |=> flags[i]);
      // R10: a clear with no set drops the flag
      assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flags[i]);
   end
endmodule

// File: rtl/pscnt_top.sv
module pscnt_top
   import pscnt_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int HALF_W = 16,
   parameter int PSC_W  = 10,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              mode,
   input  logic [SEL_W-1:0]  psc_sel,
   input  logic              clr_on_match,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_load_val,
   input  logic [HALF_W-1:0] per_val,
   input  logic [CNT_W-1:0]  cmp0_val,
   input  logic [HALF_W-1:0] cmp1_val,
   input  logic              ovf_clr,
   input  logic              cmp0_clr,
   input  logic              cmp1_clr,
   output logic [CNT_W-1:0]  count,
   output logic              ovf_flag,
   output logic              cmp0_flag,
   output logic              cmp1_flag
);
   localparam logic [CNT_W-1:0]  ALL_ONES = {CNT_W{1'b1}};
   localparam logic [HALF_W-1:0] HALF_Z   = '0;

   logic                 tick;
   logic [NUM_FLAGS-1:0] set_v, clr_v, flag_v;

   pscnt_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .sel   (psc_sel),
      .tick  (tick)
   );

   pscnt_core #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .mode         (mode),
      .clr_on_match (clr_on_match),
      .load         (cnt_load),
      .load_val     (cnt_load_val),
      .per          (per_val),
      .cmp0         (cmp0_val),
      .cmp1         (cmp1_val),
      .count        (count),
      .set_ovf      (set_v[FLAG_OVF]),
      .set_cmp0     (set_v[FLAG_CMP0]),
      .set_cmp1     (set_v[FLAG_CMP1])
   );

   assign clr_v[FLAG_OVF]  = ovf_clr;
   assign clr_v[FLAG_CMP0] = cmp0_clr;
   assign clr_v[FLAG_CMP1] = cmp1_clr;

   pscnt_flags #(.N(NUM_FLAGS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_v),
      .clr   (clr_v),
      .flags (flag_v)
   );

   assign ovf_flag  = flag_v[FLAG_OVF];
   assign cmp0_flag = flag_v[FLAG_CMP0];
   assign cmp1_flag = flag_v[FLAG_CMP1];

   // R4: full-width wrap lands on zero with overflow raised
   assert_wide_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_load && mode == MODE_WIDE && count == ALL_ONES)
      |=> (count == '0 && ovf_flag));
   // R5: a wide match raises compare flag 0 at the departing tick
   assert_cmp_next_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_load && mode == MODE_WIDE && count == cmp0_val) |=> cmp0_flag);
   // R6: clear-on-match raises both flags together and restarts at zero
   assert_clr_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_load && mode == MODE_WIDE && clr_on_match && count == cmp0_val)
      |=> (count == '0 && ovf_flag && cmp0_flag));
   // R7: split layout wraps at the period
   assert_split_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_load && mode == MODE_SPLIT && count[HALF_W-1:0] == per_val)
      |=> (count[HALF_W-1:0] == HALF_Z && ovf_flag));
   // R8: the second compare is silent in the wide layout
   assert_cmp1_wide_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_WIDE && !cmp1_flag) |=> !cmp1_flag);
endmodule

// File: tb/sim_pscnt_top.sv
module sim_pscnt_top;
   localparam int CW = 32;
   localparam int HW = 16;
   localparam int SW = 4;

   logic          clk = 1'b0, rst_n = 1'b0, en = 1'b0, mode = 1'b0;
   logic          clr_on_match = 1'b0, cnt_load = 1'b0;
   logic          ovf_clr = 1'b0, cmp0_clr = 1'b0, cmp1_clr = 1'b0;
   logic [SW-1:0] psc_sel = '0;
   logic [CW-1:0] cnt_load_val = '0, cmp0_val = '0;
   logic [HW-1:0] per_val = '0, cmp1_val = '0;
   logic [CW-1:0] count;
   logic          ovf_flag, cmp0_flag, cmp1_flag;

   int n_chk = 0, n_bad = 0;
   logic [CW-1:0] m_cnt = '0;
   logic          m_ovf = 1'b0, m_c0 = 1'b0, m_c1 = 1'b0;

   always #2 clk = ~clk;

   pscnt_top u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .psc_sel(psc_sel),
      .clr_on_match(clr_on_match), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
      .per_val(per_val), .cmp0_val(cmp0_val), .cmp1_val(cmp1_val),
      .ovf_clr(ovf_clr), .cmp0_clr(cmp0_clr), .cmp1_clr(cmp1_clr),
      .count(count), .ovf_flag(ovf_flag), .cmp0_flag(cmp0_flag), .cmp1_flag(cmp1_flag)
   );

   task automatic check(string req, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one tick of the arithmetic model, using the inputs held at the edge
   task automatic model_tick();
      logic [HW-1:0] lo;
      if (!mode) begin
         if (m_cnt == cmp0_val) m_c0 = 1'b1;
         if ((clr_on_match && m_cnt == cmp0_val) || m_cnt == 32'hFFFF_FFFF) begin
            m_cnt = '0; m_ovf = 1'b1;
         end else m_cnt = m_cnt + 1;
      end else begin
         lo = m_cnt[HW-1:0];
         if (lo == cmp0_val[HW-1:0]) m_c0 = 1'b1;
         if (lo == cmp1_val) m_c1 = 1'b1;
         if (lo == per_val || lo == 16'hFFFF) begin
            m_cnt = '0; m_ovf = 1'b1;
         end else m_cnt = {16'h0, lo + 16'h1};
      end
   endtask

   task automatic check_all(string req);
      check(req, "count", count, m_cnt);
      check(req, "ovf", {31'b0, ovf_flag}, {31'b0, m_ovf});
      check(req, "cmp0", {31'b0, cmp0_flag}, {31'b0, m_c0});
      check(req, "cmp1", {31'b0, cmp1_flag}, {31'b0, m_c1});
   endtask

   // code 0, enabled: every edge is a tick
   task automatic run(string req, int n);
      en = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         model_tick();
         check_all(req);
      end
      en = 1'b0;
   endtask

   task automatic load(logic [CW-1:0] v);
      @(negedge clk);
      cnt_load = 1'b1; cnt_load_val = v;
      @(negedge clk);
      cnt_load = 1'b0;
      m_cnt = mode ? {16'h0, v[HW-1:0]} : v;
   endtask

   task automatic clear_flags();
      @(negedge clk);
      ovf_clr = 1'b1; cmp0_clr = 1'b1; cmp1_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0; cmp0_clr = 1'b0; cmp1_clr = 1'b0;
      m_ovf = 1'b0; m_c0 = 1'b0; m_c1 = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_all("R1");

      // R2 / R3: prescaler period for every code, including clamped codes
      for (int k = 0; k < 16; k++) begin
         int per_exp, n;
         logic [CW-1:0] held;
         per_exp = 1 << ((k > 10) ? 10 : k);
         load(32'h0);
         psc_sel = SW'(k);
         en = 1'b1;
         n = 0;
         while (count == 32'h0 && n < 3000) begin @(negedge clk); n++; end
         check("R2", "first tick cycle", n, per_exp);
         while (count == 32'h1 && n < 6000) begin @(negedge clk); n++; end
         check("R2", "second tick cycle", n, 2 * per_exp);
         en = 1'b0;
         held = count;
         repeat (20) @(negedge clk);
         check("R3", "held count", count, held);
         en = 1'b1;
         n = 0;
         while (count == held && n < 3000) begin @(negedge clk); n++; end
         check("R3", "restart tick cycle", n, per_exp);
         en = 1'b0;
      end
      psc_sel = '0;
      @(negedge clk);

      // R4: full-width wrap
      mode = 1'b0; clr_on_match = 1'b0; cmp0_val = 32'h1234; cmp1_val = 16'h7777;
      load(32'hFFFF_FFFC); clear_flags();
      run("R4", 6);

      // R5: compare flag one tick after the match, several values
      for (int c = 0; c < 6; c++) begin
         cmp0_val = 32'h40 + c;
         load(32'h40); clear_flags();
         run("R5", 8);
      end

      // R6: clear-on-match period sweep
      clr_on_match = 1'b1;
      for (int c = 0; c < 8; c++) begin
         cmp0_val = c;
         load(32'h0); clear_flags();
         run("R6", 2 * (c + 1) + 1);
      end
      clr_on_match = 1'b0;

      // R7: split layout period sweep
      mode = 1'b1; cmp0_val = 32'h100; cmp1_val = 16'h100;
      for (int p = 0; p < 8; p++) begin
         per_val = p;
         load(32'h0); clear_flags();
         run("R7", 2 * p + 3);
      end
      // R7 / R9: count above period runs to all-ones; upper load bits dropped
      per_val = 16'h4;
      load(32'h1234_FFFD); clear_flags();
      check("R9", "split load", count, 32'h0000_FFFD);
      run("R7", 5);

      // R8: two split compares, upper cmp0 bits and clear-on-match ignored
      per_val = 16'd9; cmp0_val = 32'hABCD_0002; cmp1_val = 16'd5; clr_on_match = 1'b1;
      load(32'h0); clear_flags();
      run("R8", 22);
      clr_on_match = 1'b0;

      // R8: second compare silent in wide layout
      mode = 1'b0; cmp0_val = 32'h999; cmp1_val = 16'd5;
      load(32'h0); clear_flags();
      run("R8", 10);

      // R9: load during a matching tick wins and sets no flag
      cmp0_val = 32'h7;
      load(32'h5); clear_flags();
      run("R9", 2);
      en = 1'b1; cnt_load = 1'b1; cnt_load_val = 32'h300;
      @(negedge clk);
      cnt_load = 1'b0;
      m_cnt = 32'h300;
      check_all("R9");
      run("R9", 3);

      // R10: set beats clear on the wrap edge, then a lone clear drops it
      cmp0_val = 32'h999;
      load(32'hFFFF_FFFE); clear_flags();
      run("R10", 1);
      en = 1'b1; ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0; en = 1'b0;
      m_cnt = 32'h0; m_ovf = 1'b1;
      check_all("R10");
      repeat (4) @(negedge clk);
      check("R10", "sticky ovf", {31'b0, ovf_flag}, 32'h1);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      m_ovf = 1'b0;
      check_all("R10");

      finish_run();
   end
endmodule